// File: doc/BRIEF.md
# Tone Steering Guard-Time Controller

This block sits behind a dual-tone classifier. From the classifier it takes a signal-present flag and a 4-bit key code. It decides when a key press is real and when it has ended. Two digital guard timers stand in for a resistor-capacitor steering network. The timers count a slow tick, for example one pulse per millisecond.

- A tone must stay present for a programmable number of ticks before its code is registered.
- Once a digit is held, the tone must stay absent for a second programmable number of ticks before the digit is released.

Short bursts are rejected and short dropouts are bridged. With a detect time of about 5 to 14 ms ahead of the block, the present guard is sized so that the total recognition time accepts tones of 40 ms or longer and rejects tones of 20 ms or shorter.

The registered code goes into an output latch. A fixed number of clock cycles later, a delayed steering flag rises, so the data is settled before the flag announces it. The flag stays high until the absence guard expires. The code is presented on a 4-bit bus while the output enable is high, together with a drive-enable output for the pad. An inhibit input can disable the fourth tone column. A power-down input stops all timing and keeps the stored code.

Top module: `tone_steer_guard`

## Requirements
- R1: After reset the steering flag is low and the latched code is 0x0.
- R2: A qualified tone that is present for fewer than PRESENT_TICKS consecutive ticks is not registered: the latch and the flag are unchanged.
- R3: A tone that is qualified on PRESENT_TICKS consecutive ticks is registered. The code present at the last of those ticks is written into the latch at that clock edge.
- R4: The steering flag rises exactly SETTLE_CYCLES clock cycles after the latch update, and the latch does not change in the cycle the flag rises.
- R5: While the flag is high, an absence shorter than ABSENT_TICKS ticks neither lowers the flag nor registers a new code.
- R6: While the flag is high, an absence lasting ABSENT_TICKS consecutive ticks lowers the flag.
- R7: Only one registration happens per flag period: code changes while the flag is high are ignored.
- R8: While out_en is high, code_out shows the latch and bus_drive is high. While out_en is low, code_out is 0x0 and bus_drive is low.
- R9: While inhibit is high, the fourth-column codes (0xD, 0xE, 0xF, 0x0) count as no tone, and other codes are still registered.
- R10: pwr_down high lowers the flag at the next edge and clears both guard counts, and the latched code is kept.
- R11: Any break in the qualified tone before the present threshold restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle timebase pulse for the guard counts |
| early_det | input | 1 | Signal-present flag from the classifier |
| code_in | input | 4 | Key code from the classifier |
| inhibit | input | 1 | Treat fourth-column codes as no tone |
| pwr_down | input | 1 | Halt timing, clear the flag, keep the code |
| out_en | input | 1 | Enable the code onto the bus |
| code_out | output | 4 | Latched code while enabled, else zero |
| bus_drive | output | 1 | Pad drive enable for code_out |
| steer_flag | output | 1 | Delayed steering flag: a digit is held |

## Verification
The assertions assume that every input is synchronous to clk. They also assume that tick is a single-cycle pulse, and that pwr_down and the classifier flag come from registered logic, so the past-cycle input values are the ones the block acted on. The stimulus changes inputs only on the falling clock edge. The tick is a strict one-in-four pulse. The random phase mixes burst lengths on both sides of the guard thresholds with occasional inhibit, bus-enable and power-down changes. Every output is compared each cycle with a bench model built from the requirements.

// File: rtl/tsg_pkg.sv
// Package tsg_pkg: shared types and helpers for the tone steering block.
// Assumes the classifier encodes keys as 4-bit codes, with the fourth
// tone column on codes 0xD, 0xE, 0xF and 0x0.
package tsg_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HOLD   = 2'd2
    } steer_state_e;

    // True for the codes that carry the fourth column tone.
    function automatic logic is_col4(input logic [CODE_W-1:0] c);
        return (c == 4'hD) || (c == 4'hE) || (c == 4'hF) || (c == 4'h0);
    endfunction

endpackage

// File: rtl/tsg_qualify.sv
// Module tsg_qualify: turns the raw signal-present flag into a qualified
// tone flag, dropping fourth-column keys while inhibit is high.
// Assumes inputs are synchronous; purely combinational.
module tsg_qualify
    import tsg_pkg::*;
(
    input  logic              early_det,
    input  logic [CODE_W-1:0] code_in,
    input  logic              inhibit,
    output logic              tone_ok
);

    // Gate out inhibited columns.
    always_comb begin
        tone_ok = early_det && !(inhibit && is_col4(code_in));
    end

endmodule

// File: rtl/tsg_guard_timer.sv
// Module tsg_guard_timer: counts tick pulses while 'active' is held and
// flags expiry on the LIMIT-th tick. Any cycle without 'active', or with
// 'clear', restarts the count. Assumes LIMIT >= 1 and tick is one cycle wide.
module tsg_guard_timer #(
    parameter int unsigned LIMIT = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic tick,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Expiry is raised on the tick that completes the window.
    always_comb begin
        expired = active && tick && !clear && (cnt == LAST);
    end

    // Advance on ticks, restart on a break, a clear or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !active) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expired ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tsg_sequencer.sv
// Module tsg_sequencer: steering state machine. It waits for the present
// guard, loads the latch, settles for SETTLE_CYCLES clocks, raises the
// flag and holds it until the absence guard expires. Power-down returns
// it to waiting with the flag low. Assumes SETTLE_CYCLES >= 1.
module tsg_sequencer
    import tsg_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_down,
    input  logic         present_done,
    input  logic         absent_done,
    output steer_state_e state,
    output logic         load,
    output logic         steer_flag
);

    localparam int SCNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SCNT_W-1:0] SETTLE_LAST = SCNT_W'(SETTLE_CYCLES - 1);

    logic [SCNT_W-1:0] settle_cnt;

    // Latch load strobe: present guard expired while waiting.
    always_comb begin
        load = (state == ST_WAIT) && present_done && !pwr_down;
    end

    // State, settle count and flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            state      <= ST_WAIT;
            settle_cnt <= '0;
            steer_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (load) begin
                        state      <= ST_SETTLE;
                        settle_cnt <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST) begin
                        state      <= ST_HOLD;
                        steer_flag <= 1'b1;
                        settle_cnt <= '0;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (absent_done) begin
                        state      <= ST_WAIT;
                        steer_flag <= 1'b0;
                    end
                end
                default: begin
                    state      <= ST_WAIT;
                    steer_flag <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tsg_out_latch.sv
// Module tsg_out_latch: holds the registered key code and presents it on
// the output bus with a pad drive enable. The latch is written only on
// 'load' and survives power-down. When disabled the bus reads zero.
module tsg_out_latch
    import tsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              out_en,
    output logic [CODE_W-1:0] latch_q,
    output logic [CODE_W-1:0] code_out,
    output logic              bus_drive
);

    // Capture the code on a registration strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load) begin
            latch_q <= code_in;
        end
    end

    // Bus gating toward the pad.
    always_comb begin
        bus_drive = out_en;
        code_out  = out_en ? latch_q : '0;
    end

endmodule

// File: rtl/tone_steer_guard.sv
// Module tone_steer_guard: top of the steering guard-time controller.
// It qualifies the signal-present flag, runs the tone-present and
// tone-absent guard timers, and sequences latch load, settle and flag.
// Assumes all inputs are synchronous to clk and tick is a one-cycle pulse.
module tone_steer_guard
    import tsg_pkg::*;
#(
    parameter int unsigned PRESENT_TICKS = 26,
    parameter int unsigned ABSENT_TICKS  = 30,
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        early_det,
    input  logic [3:0]  code_in,
    input  logic        inhibit,
    input  logic        pwr_down,
    input  logic        out_en,
    output logic [3:0]  code_out,
    output logic        bus_drive,
    output logic        steer_flag
);

    logic              tone_ok;
    logic              present_done;
    logic              absent_done;
    logic              present_act;
    logic              absent_act;
    logic              load;
    steer_state_e      state;
    logic [CODE_W-1:0] code_latch;

    tsg_qualify u_qual (
        .early_det (early_det),
        .code_in   (code_in),
        .inhibit   (inhibit),
        .tone_ok   (tone_ok)
    );

    // Each guard runs only in the state that needs it.
    always_comb begin
        present_act = tone_ok && (state == ST_WAIT);
        absent_act  = !tone_ok && (state == ST_HOLD);
    end

    tsg_guard_timer #(.LIMIT(PRESENT_TICKS)) u_present (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pwr_down),
        .active  (present_act),
        .tick    (tick),
        .expired (present_done)
    );

    tsg_guard_timer #(.LIMIT(ABSENT_TICKS)) u_absent (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pwr_down),
        .active  (absent_act),
        .tick    (tick),
        .expired (absent_done)
    );

    tsg_sequencer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_down     (pwr_down),
        .present_done (present_done),
        .absent_done  (absent_done),
        .state        (state),
        .load         (load),
        .steer_flag   (steer_flag)
    );

    tsg_out_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .code_in   (code_in),
        .out_en    (out_en),
        .latch_q   (code_latch),
        .code_out  (code_out),
        .bus_drive (bus_drive)
    );

endmodule

// File: rtl/tsg_checker.sv
// Module tsg_checker: temporal properties of the steering controller,
// bound onto every tone_steer_guard instance.
module tsg_checker
    import tsg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        early_det,
    input logic [3:0]  code_in,
    input logic        inhibit,
    input logic        pwr_down,
    input logic        steer_flag,
    input logic [3:0]  latch_q
);

    logic blocked;

    // Input-side view of an inhibited column.
    always_comb begin
        blocked = inhibit && is_col4(code_in);
    end

    // R4: the latch is already settled in the cycle the flag rises.
    p_settled_before_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steer_flag) |-> $stable(latch_q));

    // R7: no rewrite of the latch while a digit is held.
    p_single_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        steer_flag |=> $stable(latch_q));

    // R6: the flag only falls after absence or power-down.
    p_fall_on_absence_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(steer_flag) |-> $past(pwr_down || !early_det || blocked));

    // R9: a latch change needs a present, non-inhibited tone.
    p_load_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_q) |-> $past(early_det && !blocked && !pwr_down));

    // R10: power-down drops the flag at the next edge.
    p_pd_clears_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !steer_flag);

endmodule

bind tone_steer_guard tsg_checker u_tsg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .early_det  (early_det),
    .code_in    (code_in),
    .inhibit    (inhibit),
    .pwr_down   (pwr_down),
    .steer_flag (steer_flag),
    .latch_q    (code_latch)
);

// File: tb/tone_steer_guard_bench.sv
// Bench for tone_steer_guard: directed corner cases followed by seeded
// random stimulus, with a cycle model derived from the requirements.
module tone_steer_guard_bench;

    localparam int TP  = 5;
    localparam int TA  = 3;
    localparam int ST  = 3;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       early_det = 1'b0;
    logic [3:0] code_in = 4'h0;
    logic       inhibit = 1'b0;
    logic       pwr_down = 1'b0;
    logic       out_en = 1'b1;
    logic [3:0] code_out;
    logic       bus_drive;
    logic       steer_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tone_steer_guard #(
        .PRESENT_TICKS (TP),
        .ABSENT_TICKS  (TA),
        .SETTLE_CYCLES (ST)
    ) u_tone_steer_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .early_det  (early_det),
        .code_in    (code_in),
        .inhibit    (inhibit),
        .pwr_down   (pwr_down),
        .out_en     (out_en),
        .code_out   (code_out),
        .bus_drive  (bus_drive),
        .steer_flag (steer_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit col4(input logic [3:0] c);
        return (c == 4'hD) || (c == 4'hE) || (c == 4'hF) || (c == 4'h0);
    endfunction

    // Tick: one cycle high in every DIV cycles.
    initial begin
        forever begin
            repeat (DIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // Reference model built from the requirements.
    int         m_state = 0;
    int         m_cnt = 0;
    int         m_scnt = 0;
    logic [3:0] m_code = 4'h0;
    bit         m_flag = 1'b0;
    bit         m_live = 1'b0;

    always @(posedge clk) begin
        bit qual;
        qual = early_det && !(inhibit && col4(code_in));
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_scnt = 0; m_code = 4'h0; m_flag = 0;
            m_live = 1'b1;
        end else if (pwr_down) begin
            m_state = 0; m_cnt = 0; m_scnt = 0; m_flag = 0;
        end else begin
            case (m_state)
                0: if (!qual) m_cnt = 0;
                   else if (tick) begin
                       if (m_cnt == TP - 1) begin
                           m_code = code_in; m_cnt = 0; m_scnt = 0; m_state = 1;
                       end else m_cnt++;
                   end
                1: if (m_scnt == ST - 1) begin
                       m_flag = 1; m_state = 2; m_cnt = 0; m_scnt = 0;
                   end else m_scnt++;
                default: if (qual) m_cnt = 0;
                   else if (tick) begin
                       if (m_cnt == TA - 1) begin
                           m_flag = 0; m_state = 0; m_cnt = 0;
                       end else m_cnt++;
                   end
            endcase
        end
        #2;
        if (m_live)
            chk("R3/R6/R8 model", {bus_drive, steer_flag, code_out},
                {out_en, m_flag, out_en ? m_code : 4'h0});
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int t_latch;
        int t_flag;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 flag", steer_flag, 0);
        chk("R1 code", code_out, 0);

        // R2: burst one tick short
        early_det = 1; code_in = 4'h5;
        cyc((TP - 1) * DIV);
        early_det = 0;
        cyc(6 * DIV);
        chk("R2 flag", steer_flag, 0);
        chk("R2 code", code_out, 0);

        // R11: two partial bursts split by a one-cycle gap
        early_det = 1; cyc(3 * DIV);
        early_det = 0; cyc(1);
        early_det = 1; cyc(3 * DIV);
        early_det = 0; cyc(6 * DIV);
        chk("R11 flag", steer_flag, 0);
        chk("R11 code", code_out, 0);

        // R3, R4: registration and settle ordering
        early_det = 1; code_in = 4'h9;
        t_latch = -1; t_flag = -1;
        for (int i = 1; i <= 100 && t_flag < 0; i++) begin
            @(negedge clk);
            if (t_latch < 0 && code_out == 4'h9) t_latch = i;
            if (steer_flag) t_flag = i;
        end
        chk("R3 code", code_out, 4'h9);
        chk("R3 window", (t_latch > 0 && t_latch <= TP * DIV) ? 1 : 0, 1);
        chk("R4 settle", t_flag - t_latch, ST);

        // R5: short dropout bridged
        early_det = 0; cyc((TA - 1) * DIV);
        early_det = 1; cyc(2 * DIV);
        chk("R5 flag", steer_flag, 1);
        chk("R5 code", code_out, 4'h9);

        // R7: code change while held is ignored
        code_in = 4'h3; cyc(10 * DIV);
        chk("R7 code", code_out, 4'h9);
        chk("R7 flag", steer_flag, 1);

        // R6: full absence releases
        early_det = 0; cyc(TA * DIV + 2);
        chk("R6 flag", steer_flag, 0);

        // R8: bus gating
        out_en = 0; cyc(1);
        chk("R8 off code", code_out, 0);
        chk("R8 off drive", bus_drive, 0);
        out_en = 1; cyc(1);
        chk("R8 on code", code_out, 4'h9);
        chk("R8 on drive", bus_drive, 1);

        // R9: inhibited fourth column, then a normal key under inhibit
        inhibit = 1; early_det = 1; code_in = 4'hE; cyc(10 * DIV);
        chk("R9 E flag", steer_flag, 0);
        code_in = 4'h0; cyc(10 * DIV);
        chk("R9 0 code", code_out, 4'h9);
        code_in = 4'h7; cyc(TP * DIV + ST + 2);
        chk("R9 7 code", code_out, 4'h7);
        chk("R9 7 flag", steer_flag, 1);
        early_det = 0; inhibit = 0; cyc(TA * DIV + 2);

        // R10: power-down keeps the code, clears the flag
        early_det = 1; code_in = 4'h2; cyc(TP * DIV + ST + 2);
        chk("R10 pre flag", steer_flag, 1);
        pwr_down = 1; cyc(1);
        chk("R10 flag", steer_flag, 0);
        cyc(10 * DIV);
        chk("R10 hold flag", steer_flag, 0);
        chk("R10 code", code_out, 4'h2);
        pwr_down = 0; early_det = 0; cyc(TA * DIV + 2);

        // Random phase, checked by the model every cycle
        for (int s = 0; s < 400; s++) begin
            early_det = $urandom % 2;
            code_in   = 4'($urandom % 16);
            inhibit   = ($urandom % 5) == 0;
            out_en    = ($urandom % 4) != 0;
            pwr_down  = ($urandom % 30) == 0;
            cyc(1 + $urandom % (8 * DIV));
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule